// File: doc/BRIEF.md
# SD Card Clock Control Unit

This unit turns a free-running base clock into the clock that drives a memory card. Software controls it through one 16-bit control word. The upper byte holds a divisor. The low bits hold an internal-clock enable, a read-only "clock stable" flag and a card-clock enable.

The expected sequence has three steps. Software first writes zero, which halts everything. It then writes the divisor together with the internal enable. It polls the stable flag, and once the flag is set it sets the card-clock enable.

The divided clock comes out of a register, so its edges are clean. The card-clock enable is refused while the internal clock is not yet stable. A new divisor is adopted only at the end of a high phase, so no runt pulse reaches the card.

Top module: `sdclk_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000 and the card clock output is low.
- R2: A write stores the divisor in bits 15:8 and the internal enable in bit 0. Both read back unchanged. Bits 7:3 always read zero.
- R3: Bit 1 is the stable flag and is read-only. Writing a 1 to bit 1 while the internal enable is clear leaves it reading 0.
- R4: The stable flag reads 1 exactly STABLE_CYC (default 16) clock cycles after the cycle in which a write with bit 0 set was captured. It reads 0 from the first cycle after a write that clears bit 0.
- R5: Bit 2 (card enable) is accepted only if the write also sets bit 0 and the stable flag is already 1 at the time of the write. Otherwise bit 2 reads 0 and the card clock stays low.
- R6: With divisor N ≥ 1, the card clock is high for N cycles and low for N cycles, a period of 2N. Divisor 0 behaves like divisor 1.
- R7: A divisor written while the clock runs takes effect only at the end of a high phase. Every high or low pulse therefore lasts either the old or the new divisor count.
- R8: Writing 0x0000 stops the card clock: from the second cycle after the write it stays low. The flags and the divisor field all read zero.
- R9: A high phase of the card clock begins only if the card enable read 1 in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock, also the control word's clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word write value |
| rd_data | output | 16 | Control word read value: divisor, card enable, stable, internal enable |
| card_clk_o | output | 1 | Divided, gated card clock (registered) |

## Verification
The bench builds the block with its default values: an 8-bit divisor and a 16-cycle stable delay. With these values it can sweep divisors from 0 up to the full-scale value 255, which gives a 510-cycle period. It also times the exact stable-flag delay and checks that an early card-enable request is refused.

A divisor change from 4 to 2 in the middle of a run shows that every pulse lasts one of the two legal lengths. That test also confirms the new period once the change has settled.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  // Bit positions of the control word (fixed by the software sequence)
  localparam int BIT_INT_EN  = 0;
  localparam int BIT_STABLE  = 1;
  localparam int BIT_CARD_EN = 2;
  localparam int DIV_LSB     = 8;

  typedef struct packed {
    logic int_en;
    logic card_en;
  } sdclk_en_t;
endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 8,
  localparam int REG_W = DIV_LSB + DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             stable,
  output sdclk_en_t        en_o,
  output logic [DIV_W-1:0] div_o
);
  sdclk_en_t        en_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      div_q <= '0;
    end else if (wr_en) begin
      div_q      <= wr_data[DIV_LSB +: DIV_W];
      en_q.int_en <= wr_data[BIT_INT_EN];
      // card enable refused until the internal clock is stable
      en_q.card_en <= wr_data[BIT_CARD_EN] & wr_data[BIT_INT_EN] & stable;
    end
  end

  assign en_o  = en_q;
  assign div_o = div_q;
endmodule

// File: rtl/sdclk_stable.sv
module sdclk_stable #(
  parameter int STABLE_CYC = 16,
  localparam int CNT_W = $clog2(STABLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic stable_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             stable_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!stable_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(STABLE_CYC - 1)) stable_q <= 1'b1;
    end
  end

  // flag drops together with the enable
  assign stable_o = stable_q & run;
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             card_en,
  input  logic [DIV_W-1:0] div_req,
  output logic [DIV_W-1:0] div_act_o,
  output logic             phase_o,
  output logic             card_clk_o
);
  logic [DIV_W-1:0] cnt_q, div_act_q, lim;
  logic             phase_q, gate_q, out_q;
  logic             term, phase_n, gate_n;

  always_comb begin
    lim     = (div_act_q == '0) ? DIV_W'(1) : div_act_q;
    term    = (cnt_q == lim - 1'b1);
    phase_n = term ? ~phase_q : phase_q;
    // enable is sampled only while the clock is low
    gate_n  = phase_q ? gate_q : card_en;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q     <= '0;
      phase_q   <= 1'b0;
      gate_q    <= 1'b0;
      out_q     <= 1'b0;
      div_act_q <= rst ? '0 : div_req;
    end else begin
      cnt_q   <= term ? '0 : cnt_q + 1'b1;
      phase_q <= phase_n;
      gate_q  <= gate_n;
      out_q   <= phase_n & gate_n;
      if (term && phase_q) div_act_q <= div_req;
    end
  end

  assign div_act_o  = div_act_q;
  assign phase_o    = phase_q;
  assign card_clk_o = out_q;
endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int STABLE_CYC = 16,
  localparam int REG_W     = DIV_LSB + DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             card_clk_o
);
  sdclk_en_t        en;
  logic [DIV_W-1:0] div_req, div_act;
  logic             stable, phase;

  sdclk_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .stable(stable), .en_o(en), .div_o(div_req)
  );

  sdclk_stable #(.STABLE_CYC(STABLE_CYC)) u_stable (
    .clk(clk), .rst(rst), .run(en.int_en), .stable_o(stable)
  );

  sdclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(en.int_en), .card_en(en.card_en),
    .div_req(div_req), .div_act_o(div_act), .phase_o(phase),
    .card_clk_o(card_clk_o)
  );

  always_comb begin
    rd_data                      = '0;
    rd_data[DIV_LSB +: DIV_W]    = div_req;
    rd_data[BIT_INT_EN]          = en.int_en;
    rd_data[BIT_STABLE]          = stable;
    rd_data[BIT_CARD_EN]         = en.card_en;
  end
endmodule

// File: rtl/sdclk_ctrl_checker.sv
module sdclk_ctrl_checker #(
  parameter int DIV_W      = 8,
  parameter int STABLE_CYC = 16,
  localparam int REG_W     = 8 + DIV_W,
  localparam int CW        = $clog2(STABLE_CYC + 1) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] rd_data,
  input logic             card_clk_o,
  input logic [DIV_W-1:0] div_act,
  input logic             phase
);
  logic [CW-1:0] on_cnt;

  always_ff @(posedge clk) begin
    if (rst || !rd_data[0]) on_cnt <= '0;
    else if (on_cnt < CW'(STABLE_CYC)) on_cnt <= on_cnt + 1'b1;
  end

  a_r4_not_early: assert property (@(posedge clk) disable iff (rst)
    rd_data[1] |-> on_cnt >= CW'(STABLE_CYC));
  a_r4_not_late: assert property (@(posedge clk) disable iff (rst)
    (rd_data[0] && on_cnt >= CW'(STABLE_CYC)) |-> rd_data[1]);
  a_r5_card_needs_stable: assert property (@(posedge clk) disable iff (rst)
    rd_data[2] |-> (rd_data[1] && rd_data[0]));
  a_r8_stopped_low: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[0] && !$past(rd_data[0])) |-> !card_clk_o);
  a_r9_rise_needs_en: assert property (@(posedge clk) disable iff (rst)
    $rose(card_clk_o) |-> $past(rd_data[2]));
  a_r7_div_swap_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_act) |-> !phase);
  a_r2_spare_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:3] == 5'd0);
endmodule

bind sdclk_ctrl sdclk_ctrl_checker #(.DIV_W(DIV_W), .STABLE_CYC(STABLE_CYC)) u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .card_clk_o(card_clk_o),
  .div_act(div_act), .phase(phase)
);

// File: tb/sdclk_ctrl_bench.sv
module sdclk_ctrl_bench;
  localparam int NV = 6;
  localparam int VEC_DIV[NV]  = '{0, 1, 2, 3, 7, 255};
  localparam int VEC_HALF[NV] = '{1, 1, 2, 3, 7, 255};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        card_clk_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sdclk_ctrl u_sdclk_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .card_clk_o(card_clk_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_lvl(input logic v);
    for (int i = 0; i < 2000 && card_clk_o != v; i++) @(negedge clk);
  endtask

  task automatic pulse_len(input logic v, output int n);
    n = 0;
    while (card_clk_o == v && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic bring_up(input logic [7:0] dv, output int lat);
    wr(16'h0000);
    wr({dv, 8'h01});
    lat = 0;
    while (!rd_data[1] && lat < 100) begin @(negedge clk); lat++; end
    wr({dv, 8'h05});
  endtask

  initial begin
    int lat, hi, lo;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_data == 16'h0000, "R1 reset word", rd_data, 0);
    chk(card_clk_o == 1'b0, "R1 reset clock", card_clk_o, 0);

    for (int v = 0; v < NV; v++) begin
      bring_up(8'(VEC_DIV[v]), lat);
      chk(lat == 16, "R4 stable delay", lat, 16);
      chk(rd_data == {8'(VEC_DIV[v]), 8'h07}, "R2 readback", rd_data, {8'(VEC_DIV[v]), 8'h07});
      wait_lvl(1'b0); wait_lvl(1'b1);
      pulse_len(1'b1, hi);
      pulse_len(1'b0, lo);
      chk(hi == VEC_HALF[v], "R6 high length", hi, VEC_HALF[v]);
      chk(lo == VEC_HALF[v], "R6 low length", lo, VEC_HALF[v]);
    end

    // R8: stop
    wr(16'h0000);
    chk(rd_data == 16'h0000, "R8 word after stop", rd_data, 0);
    @(negedge clk);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      if (card_clk_o) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R8 clock stays low", hi, 0);

    // R3: stable bit not writable
    wr(16'h0002);
    chk(rd_data[1] == 1'b0, "R3 stable read-only", rd_data[1], 0);

    // R5: early card enable refused
    wr(16'h0000);
    wr(16'h0305);
    chk(rd_data[2] == 1'b0, "R5 early enable refused", rd_data[2], 0);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      if (card_clk_o) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R5 R9 no clock without enable", hi, 0);
    // R5: enable with bit 0 clear refused even when stable
    wr(16'h0004);
    chk(rd_data[2] == 1'b0, "R5 enable needs bit0", rd_data[2], 0);

    // R4: stable clears right after enable cleared
    bring_up(8'd4, lat);
    wr(16'h0400);
    chk(rd_data[1] == 1'b0, "R4 stable clears", rd_data[1], 0);

    // R7: divisor change while running
    bring_up(8'd4, lat);
    wait_lvl(1'b0); wait_lvl(1'b1);
    pulse_len(1'b1, hi);
    chk(hi == 4, "R7 before change", hi, 4);
    wr(16'h0205);
    wait_lvl(~card_clk_o);
    for (int p = 0; p < 8; p++) begin
      logic lv;
      lv = card_clk_o;
      pulse_len(lv, hi);
      chk(hi == 2 || hi == 4, "R7 legal pulse", hi, 2);
    end
    wait_lvl(1'b0); wait_lvl(1'b1);
    pulse_len(1'b1, hi);
    pulse_len(1'b0, lo);
    chk(hi == 2 && lo == 2, "R7 new period", hi + lo, 4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule